// File: doc/BRIEF.md
# Watermark-Interrupt Serial Port

This block is a serial transmitter and receiver that sits behind a small 32-bit register bus. The CPU writes bytes into an 8-entry send queue. A serializer drains the queue onto `txd` as frames. Each frame is one low start bit, 8 data bits sent least significant bit first, and one or two high stop bits. A deserializer oversamples `rxd` sixteen times per bit and puts good frames into an 8-entry receive queue, which the CPU empties by reading. Frames carry no parity. The block has no flow control, no break handling and no modem lines.

The interrupt is a level signal. Software sets a threshold for each queue. The transmit side is pending while its queue holds fewer entries than the threshold. The receive side is pending while its queue holds more entries than the threshold. The `irq` output is the OR of the pending bits that are enabled. The only line settings are a 16-bit divisor, where one bit lasts divisor+1 clocks, and the stop-bit count.

The serializer has four states: `TX_IDLE`, `TX_START`, `TX_DATA` and `TX_STOP`.
- `TX_IDLE` to `TX_START` when the transmitter is enabled and the queue is not empty. The byte is popped in that cycle.
- `TX_START` to `TX_DATA` at the end of the start bit.
- `TX_DATA` stays in `TX_DATA` for each bit until the eighth bit ends, then goes to `TX_STOP`.
- `TX_STOP` goes back to `TX_IDLE` after one stop period. With two stop bits selected, it goes back after two.

The deserializer also has four states: `RX_IDLE`, `RX_START`, `RX_DATA` and `RX_STOP`.
- `RX_IDLE` to `RX_START` on a falling edge of the synchronized line while reception is enabled.
- `RX_START` to `RX_DATA` if the line is still low at the middle of the start bit. It goes back to `RX_IDLE` if the line is high there.
- `RX_DATA` to `RX_STOP` after the eighth mid-bit sample.
- `RX_STOP` to `RX_IDLE` at the middle of the stop bit. The byte is queued only if the line is high there.

Top module: `uart_wm`

## Requirements
- R1: After reset:
  - `txd` is high and `irq` is low.
  - The send-queue full flag (bit 31 at offset 0x00) is 0 and the receive-empty flag (bit 31 at offset 0x04) is 1.
  - The pending register (offset 0x14) reads 0, the transmit control register (offset 0x08) reads 0, and the divisor (offset 0x18, bits 15:0) reads 15.
- R2: A write to offset 0x00 queues bits 7:0. Once 8 bytes wait, bit 31 at offset 0x00 reads 1 and a further write is dropped. Bytes leave in the order they were written.
- R3: Each frame has the following shape, with every bit lasting divisor+1 clocks:
  - a low start bit;
  - 8 data bits, least significant first;
  - a high stop bit.
- R4: When bit 1 of offset 0x08 is set, the serializer holds two stop-bit periods before the next start bit. When it is clear, the serializer holds one.
- R5: A read of offset 0x04 returns the oldest received byte in bits 7:0 and removes it. On an empty queue the read returns bit 31 set and removes nothing.
- R6: Bit 0 of offset 0x14 is 1 exactly while the send-queue level is below the count in bits 18:16 of offset 0x08.
- R7: Bit 1 of offset 0x14 is 1 exactly while the receive-queue level is above the count in bits 18:16 of offset 0x0C.
- R8: `irq` equals the OR of the enable bits (offset 0x10: bit 1 receive, bit 0 transmit) ANDed with the matching pending bits. Writes to offset 0x14 change nothing.
- R9: A frame whose stop bit samples low is discarded, and the next good frame is still received.
- R10: With bit 0 of offset 0x08 clear, queued bytes stay queued and `txd` stays high. With bit 0 of offset 0x0C clear, incoming frames are ignored.
- R11: A write to the send queue in the same cycle as the serializer's pop loses no byte and duplicates none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the strobe |
| rxd | input | 1 | Serial input, idles high |
| txd | output | 1 | Serial output, idles high |
| irq | output | 1 | Level interrupt |

## Verification
The bus write into the send queue and the serializer's pop of that queue can fall in the same cycle. The bench provokes this with an enabled, idle transmitter. It writes three bytes on consecutive cycles, so the second write lands in the cycle the serializer takes the first byte. A line monitor decodes every frame on `txd` against a scoreboard queue filled by the driver, and the looped-back receiver must return the same three bytes in order. Any lost or repeated byte shows up both as a scoreboard mismatch and as a wrong read-back.

// File: rtl/uart_wm_pkg.sv
package uart_wm_pkg;
    typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_e;
    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

    localparam int DIV_W = 16;
    localparam int WM_W  = 3;

    localparam logic [4:0] OFS_TXQ   = 5'h00;
    localparam logic [4:0] OFS_RXQ   = 5'h04;
    localparam logic [4:0] OFS_TXCFG = 5'h08;
    localparam logic [4:0] OFS_RXCFG = 5'h0C;
    localparam logic [4:0] OFS_IEN   = 5'h10;
    localparam logic [4:0] OFS_IPEND = 5'h14;
    localparam logic [4:0] OFS_BAUD  = 5'h18;
endpackage

// File: rtl/uart_wm_fifo.sv
module uart_wm_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          full,
    output logic          empty,
    output logic [LW-1:0] level
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    assign full    = (level == LW'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (do_push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            if (do_push && !do_pop)      level <= level + 1'b1;
            else if (do_pop && !do_push) level <= level - 1'b1;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        full && push && !pop |=> $stable(level)); // R2
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        empty && pop && !push |=> empty); // R5
    AST_PUSH_POP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !empty && !full && push && pop |=> $stable(level)); // R11
endmodule

// File: rtl/uart_wm_tx.sv
module uart_wm_tx
    import uart_wm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             two_stop,
    input  logic [DIV_W-1:0] div,
    input  logic             q_empty,
    input  logic [7:0]       q_data,
    output logic             q_pop,
    output logic             txd
);
    tx_state_e        state;
    logic [DIV_W-1:0] cnt;
    logic [2:0]       bitn;
    logic [7:0]       sh;
    logic             second_stop;
    logic             period_end;

    assign period_end = (cnt == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state       <= TX_IDLE;
            cnt         <= '0;
            bitn        <= '0;
            sh          <= '0;
            second_stop <= 1'b0;
        end else begin
            unique case (state)
                TX_IDLE: begin
                    if (q_pop) begin
                        sh    <= q_data;
                        cnt   <= '0;
                        state <= TX_START;
                    end
                end
                TX_START: begin
                    if (period_end) begin
                        cnt   <= '0;
                        bitn  <= '0;
                        state <= TX_DATA;
                    end else cnt <= cnt + 1'b1;
                end
                TX_DATA: begin
                    if (period_end) begin
                        cnt <= '0;
                        sh  <= {1'b0, sh[7:1]};
                        if (bitn == 3'd7) begin
                            second_stop <= 1'b0;
                            state       <= TX_STOP;
                        end else bitn <= bitn + 1'b1;
                    end else cnt <= cnt + 1'b1;
                end
                TX_STOP: begin
                    if (period_end) begin
                        cnt <= '0;
                        if (two_stop && !second_stop) second_stop <= 1'b1;
                        else                          state <= TX_IDLE;
                    end else cnt <= cnt + 1'b1;
                end
            endcase
        end
    end

    always_comb begin
        q_pop = 1'b0;
        txd   = 1'b1;
        unique case (state)
            TX_IDLE:  q_pop = en && !q_empty;
            TX_START: txd = 1'b0;
            TX_DATA:  txd = sh[0];
            TX_STOP:  txd = 1'b1;
        endcase
    end

    AST_TX_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_IDLE) && !en |=> (state == TX_IDLE)); // R10
endmodule

// File: rtl/uart_wm_rx.sv
module uart_wm_rx
    import uart_wm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    input  logic             rxd,
    output logic             push,
    output logic [7:0]       dout
);
    localparam int TW = DIV_W - 3;

    rx_state_e     state;
    logic          s1, s2, s_prev;
    logic [TW-1:0] tcnt, tick_lim;
    logic [DIV_W:0] div_p1;
    logic          tick;
    logic [3:0]    os;
    logic [2:0]    bitn;
    logic [7:0]    sh;

    assign div_p1   = {1'b0, div} + 1'b1;
    assign tick_lim = (div_p1[DIV_W:4] == '0) ? TW'(1) : div_p1[DIV_W:4];
    assign tick     = (state != RX_IDLE) && (tcnt == tick_lim - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1     <= 1'b1;
            s2     <= 1'b1;
            s_prev <= 1'b1;
            tcnt   <= '0;
            state  <= RX_IDLE;
            os     <= '0;
            bitn   <= '0;
            sh     <= '0;
        end else begin
            s1     <= rxd;
            s2     <= s1;
            s_prev <= s2;
            if (state == RX_IDLE || tick) tcnt <= '0;
            else                          tcnt <= tcnt + 1'b1;
            unique case (state)
                RX_IDLE: begin
                    if (en && s_prev && !s2) begin
                        os    <= '0;
                        state <= RX_START;
                    end
                end
                RX_START: begin
                    if (tick) begin
                        if (os == 4'd7) begin
                            os    <= '0;
                            bitn  <= '0;
                            state <= s2 ? RX_IDLE : RX_DATA;
                        end else os <= os + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (tick) begin
                        if (os == 4'd15) begin
                            os <= '0;
                            sh <= {s2, sh[7:1]};
                            if (bitn == 3'd7) state <= RX_STOP;
                            else              bitn  <= bitn + 1'b1;
                        end else os <= os + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (tick) begin
                        if (os == 4'd15) state <= RX_IDLE;
                        else             os    <= os + 1'b1;
                    end
                end
            endcase
        end
    end

    always_comb begin
        push = (state == RX_STOP) && tick && (os == 4'd15) && s2;
        dout = sh;
    end

    AST_RX_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_IDLE) && !en |=> (state == RX_IDLE)); // R10
    AST_RX_BAD_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_STOP) && !s2 |-> !push); // R9
endmodule

// File: rtl/uart_wm.sv
module uart_wm
    import uart_wm_pkg::*;
#(
    parameter int               DEPTH     = 8,
    parameter logic [DIV_W-1:0] RESET_DIV = 16'd15
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_we,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        rxd,
    output logic        txd,
    output logic        irq
);
    localparam int LW = $clog2(DEPTH) + 1;

    logic             tx_en, two_stop, rx_en;
    logic [WM_W-1:0]  tx_wm, rx_wm;
    logic [1:0]       ien, ipend;
    logic [DIV_W-1:0] div;
    logic             wr, tx_push, rx_pop;
    logic             tx_full, tx_empty, tx_pop, rx_full, rx_empty, rx_push;
    logic [7:0]       tx_head, rx_head, rx_byte;
    logic [LW-1:0]    tx_level, rx_level;
    logic             unused_bits;

    assign wr          = bus_sel && bus_we;
    assign tx_push     = wr && (bus_addr == OFS_TXQ);
    assign rx_pop      = bus_sel && !bus_we && (bus_addr == OFS_RXQ);
    assign ipend[0]    = tx_level < LW'(tx_wm);
    assign ipend[1]    = rx_level > LW'(rx_wm);
    assign irq         = |(ien & ipend);
    assign unused_bits = ^{bus_wdata[31:19], rx_full};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_en    <= 1'b0;
            two_stop <= 1'b0;
            tx_wm    <= '0;
            rx_en    <= 1'b0;
            rx_wm    <= '0;
            ien      <= '0;
            div      <= RESET_DIV;
        end else if (wr) begin
            case (bus_addr)
                OFS_TXCFG: begin
                    tx_en    <= bus_wdata[0];
                    two_stop <= bus_wdata[1];
                    tx_wm    <= bus_wdata[18:16];
                end
                OFS_RXCFG: begin
                    rx_en <= bus_wdata[0];
                    rx_wm <= bus_wdata[18:16];
                end
                OFS_IEN:  ien <= bus_wdata[1:0];
                OFS_BAUD: div <= bus_wdata[15:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_TXQ: bus_rdata[31] = tx_full;
            OFS_RXQ: begin
                bus_rdata[31] = rx_empty;
                if (!rx_empty) bus_rdata[7:0] = rx_head;
            end
            OFS_TXCFG: begin
                bus_rdata[18:16] = tx_wm;
                bus_rdata[1]     = two_stop;
                bus_rdata[0]     = tx_en;
            end
            OFS_RXCFG: begin
                bus_rdata[18:16] = rx_wm;
                bus_rdata[0]     = rx_en;
            end
            OFS_IEN:   bus_rdata[1:0]  = ien;
            OFS_IPEND: bus_rdata[1:0]  = ipend;
            OFS_BAUD:  bus_rdata[15:0] = div;
            default: ;
        endcase
    end

    uart_wm_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .din(bus_wdata[7:0]),
        .pop(tx_pop), .dout(tx_head), .full(tx_full), .empty(tx_empty),
        .level(tx_level));

    uart_wm_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_byte),
        .pop(rx_pop), .dout(rx_head), .full(rx_full), .empty(rx_empty),
        .level(rx_level));

    uart_wm_tx u_tx (
        .clk(clk), .rst_n(rst_n), .en(tx_en), .two_stop(two_stop), .div(div),
        .q_empty(tx_empty), .q_data(tx_head), .q_pop(tx_pop), .txd(txd));

    uart_wm_rx u_rx (
        .clk(clk), .rst_n(rst_n), .en(rx_en), .div(div), .rxd(rxd),
        .push(rx_push), .dout(rx_byte));

    AST_RX_PEND_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        rx_empty |-> !ipend[1]); // R7
    AST_TX_PEND_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        tx_full |-> !ipend[0]); // R6
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == 2'b00) |-> !irq); // R8
endmodule

// File: tb/tb_uart_wm.sv
`timescale 1ns/1ps
module tb_uart_wm;
    localparam logic [4:0] A_TXQ = 5'h00, A_RXQ = 5'h04, A_TXCFG = 5'h08,
                           A_RXCFG = 5'h0C, A_IEN = 5'h10, A_IPEND = 5'h14,
                           A_BAUD = 5'h18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, we = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        drv_rxd = 1'b1, loop = 1'b0;
    logic        rxd, txd, irq;

    int checks = 0, fails = 0, mon_frames = 0;
    int bit_ns = 128;
    logic [7:0] tx_exp_q[$];

    assign rxd = loop ? txd : drv_rxd;
    always #4 clk = ~clk;

    uart_wm dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .rxd(rxd), .txd(txd), .irq(irq));

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); sel = 1; we = 1; addr = a; wdata = d;
        @(negedge clk); sel = 0; we = 0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk); sel = 1; we = 0; addr = a;
        #1 d = rdata;
        @(negedge clk); sel = 0;
    endtask

    task automatic send_tx(input logic [7:0] b, input bit accepted);
        wr(A_TXQ, {24'h0, b});
        if (accepted) tx_exp_q.push_back(b);
    endtask

    task automatic tx_burst(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
        @(negedge clk); sel = 1; we = 1; addr = A_TXQ; wdata = {24'h0, b0};
        tx_exp_q.push_back(b0);
        @(negedge clk); wdata = {24'h0, b1}; tx_exp_q.push_back(b1);
        @(negedge clk); wdata = {24'h0, b2}; tx_exp_q.push_back(b2);
        @(negedge clk); sel = 0; we = 0;
    endtask

    task automatic send_rx(input logic [7:0] b, input bit good_stop);
        @(negedge clk);
        drv_rxd = 0; #(bit_ns);
        for (int i = 0; i < 8; i++) begin drv_rxd = b[i]; #(bit_ns); end
        drv_rxd = good_stop; #(bit_ns);
        drv_rxd = 1; #(2 * bit_ns);
    endtask

    // monitor: decodes frames on txd and compares with the scoreboard
    initial begin
        logic [7:0] v;
        logic [7:0] e;
        wait (rst_n);
        forever begin
            @(negedge txd);
            #(2 + bit_ns / 2);
            chk(txd == 1'b0, "R3", "start bit", txd, 0);
            v = '0;
            for (int i = 0; i < 8; i++) begin #(bit_ns); v[i] = txd; end
            #(bit_ns);
            chk(txd == 1'b1, "R3", "stop bit", txd, 1);
            if (tx_exp_q.size() == 0) chk(1'b0, "R2", "unexpected frame", v, 0);
            else begin
                e = tx_exp_q.pop_front();
                chk(v == e, "R3", "frame data", v, e);
            end
            mon_frames++;
        end
    end

    initial begin
        #1_000_000;
        checks++; fails++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (5) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk(txd == 1'b1, "R1", "txd idle", txd, 1);
        chk(irq == 1'b0, "R1", "irq", irq, 0);
        rd(A_TXQ, d);   chk(d[31] == 1'b0, "R1", "tx full flag", d[31], 0);
        rd(A_RXQ, d);   chk(d[31] == 1'b1, "R1", "rx empty flag", d[31], 1);
        rd(A_IPEND, d); chk(d == 0, "R1", "pending", d, 0);
        rd(A_TXCFG, d); chk(d == 0, "R1", "tx control", d, 0);
        rd(A_BAUD, d);  chk(d == 15, "R1", "divisor", d, 15);

        // receive path, watermark and interrupt
        wr(A_RXCFG, 32'h1);
        wr(A_IEN, 32'h2);
        rd(A_IPEND, d); chk(d[1] == 1'b0, "R7", "rx pend empty", d[1], 0);
        send_rx(8'hA5, 1);
        rd(A_IPEND, d); chk(d[1] == 1'b1, "R7", "rx pend 1>0", d[1], 1);
        chk(irq == 1'b1, "R8", "irq raised", irq, 1);
        wr(A_RXCFG, 32'h0001_0001);
        rd(A_IPEND, d); chk(d[1] == 1'b0, "R7", "rx pend 1>1", d[1], 0);
        chk(irq == 1'b0, "R8", "irq dropped", irq, 0);
        wr(A_IPEND, 32'hFFFF_FFFF);
        rd(A_IPEND, d); chk(d == 0, "R8", "pending write ignored", d, 0);
        wr(A_RXCFG, 32'h1);
        send_rx(8'h3C, 1);
        rd(A_RXQ, d); chk(d == 32'hA5, "R5", "oldest byte", d, 32'hA5);
        rd(A_RXQ, d); chk(d == 32'h3C, "R5", "second byte", d, 32'h3C);
        rd(A_RXQ, d); chk(d[31] == 1'b1, "R5", "empty flag", d[31], 1);
        rd(A_IPEND, d); chk(d == 0, "R5", "no pop on empty", d, 0);

        // R9 bad stop bit
        send_rx(8'h66, 0);
        rd(A_RXQ, d); chk(d[31] == 1'b1, "R9", "bad frame dropped", d[31], 1);
        send_rx(8'h5A, 1);
        rd(A_RXQ, d); chk(d == 32'h5A, "R9", "next frame kept", d, 32'h5A);

        // R10 receiver disabled
        wr(A_RXCFG, 32'h0);
        send_rx(8'h11, 1);
        wr(A_RXCFG, 32'h1);
        rd(A_RXQ, d); chk(d[31] == 1'b1, "R10", "rx disabled ignores", d[31], 1);

        // transmit queue fill, watermark, discard
        wr(A_TXCFG, 32'h0001_0000);
        rd(A_IPEND, d); chk(d[0] == 1'b1, "R6", "tx pend 0<1", d[0], 1);
        for (int i = 0; i < 9; i++) send_tx(8'h10 + 8'(i), i < 8);
        rd(A_TXQ, d);   chk(d[31] == 1'b1, "R2", "tx full flag", d[31], 1);
        rd(A_IPEND, d); chk(d[0] == 1'b0, "R6", "tx pend 8<1", d[0], 0);
        repeat (50) @(negedge clk);
        chk(txd == 1'b1, "R10", "tx disabled line high", txd, 1);
        chk(mon_frames == 0, "R10", "no frames while off", mon_frames, 0);
        loop = 1;
        wr(A_RXCFG, 32'h0007_0001);
        wr(A_TXCFG, 32'h0001_0001);
        repeat (1400) @(negedge clk);
        rd(A_IPEND, d); chk(d == 3, "R6", "both pending after drain", d, 3);
        chk(mon_frames == 8, "R2", "frames sent", mon_frames, 8);
        for (int i = 0; i < 8; i++) begin
            rd(A_RXQ, d);
            chk(d == 32'h10 + i, "R2", "loopback order", d, 32'h10 + i);
        end
        rd(A_RXQ, d); chk(d[31] == 1'b1, "R2", "ninth byte dropped", d[31], 1);

        // R11 write lands on the serializer's pop cycle
        wr(A_RXCFG, 32'h1);
        tx_burst(8'hC3, 8'h3C, 8'h99);
        repeat (600) @(negedge clk);
        chk(mon_frames == 11, "R11", "burst frames", mon_frames, 11);
        rd(A_RXQ, d); chk(d == 32'hC3, "R11", "burst byte 0", d, 32'hC3);
        rd(A_RXQ, d); chk(d == 32'h3C, "R11", "burst byte 1", d, 32'h3C);
        rd(A_RXQ, d); chk(d == 32'h99, "R11", "burst byte 2", d, 32'h99);
        rd(A_RXQ, d); chk(d[31] == 1'b1, "R11", "no duplicate", d[31], 1);

        // R3/R4 timing at divisor 31, two stop bits
        loop = 0;
        wr(A_BAUD, 32'd31);
        bit_ns = 256;
        wr(A_TXCFG, 32'h0001_0002);
        send_tx(8'h81, 1); send_tx(8'h81, 1);
        wr(A_TXCFG, 32'h0001_0003);
        @(negedge txd); #2;
        #(bit_ns / 2);  chk(txd == 1'b0, "R3", "start at 0.5", txd, 0);
        #(bit_ns);      chk(txd == 1'b1, "R3", "bit0 at 1.5", txd, 1);
        #(bit_ns);      chk(txd == 1'b0, "R3", "bit1 at 2.5", txd, 0);
        #(6 * bit_ns);  chk(txd == 1'b1, "R3", "bit7 at 8.5", txd, 1);
        #(bit_ns);      chk(txd == 1'b1, "R3", "stop at 9.5", txd, 1);
        #(bit_ns);      chk(txd == 1'b1, "R4", "second stop at 10.5", txd, 1);
        #(bit_ns);      chk(txd == 1'b0, "R4", "next start at 11.5", txd, 0);
        repeat (400) @(negedge clk);
        // one stop bit
        wr(A_TXCFG, 32'h0001_0000);
        send_tx(8'h81, 1); send_tx(8'h81, 1);
        wr(A_TXCFG, 32'h0001_0001);
        @(negedge txd); #2;
        #(bit_ns * 21 / 2); chk(txd == 1'b0, "R4", "one stop: start at 10.5", txd, 0);
        repeat (400) @(negedge clk);
        chk(mon_frames == 15, "R4", "all frames seen", mon_frames, 15);
        chk(tx_exp_q.size() == 0, "R3", "scoreboard drained", tx_exp_q.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule